// File: doc/BRIEF.md
# Converter Register Controller

This block sits between a byte-wide register bus and one successive-approximation converter. Software uses it to pick a channel, input mode and range, to drive a small sub-multiplexer select field and four open-collector digital lines, and to choose which sources may start a conversion. A conversion can begin on a software write, on a rising edge of an external start pin, or on a terminal-count pulse from a timer.

The converter is modelled as a handshake. The block pulses a start strobe for one cycle. Some cycles later the converter returns one done pulse carrying a 12-bit result. The block stores that result as the low twelve bits of a 16-bit word. The top four bits of the word are a tag: the low four sub-multiplexer select bits as they stood when the conversion started. A busy flag covers the time from start to done. The block can raise an interrupt at each completion, and a read of the status register acknowledges it.

Top module: `adc_regs_ctrl`

## Requirements
- R1: After reset the status byte reads 0x80, the control byte reads 0, no conversion is started, and `irq_o`, `dio_pull_o` and `submux_o` are all zero.
- R2: A write of any value to address 0 while idle produces exactly one one-cycle pulse on `conv_start_o`.
- R3: Address 2 holds the control byte, laid out as channel in bits 7:4, differential select in bit 3 (1 = differential) and range in bits 2:0. It drives `chan_o`, `diff_o` and `range_o` and reads back as stored. When bit 3 is written as 1, channel bit 3 (byte bit 7) is stored and read as 0.
- R4: A read at address 0 returns the last result in bits 11:0. Bits 15:12 hold the value of `submux_o[3:0]` at the start of that conversion; later writes to address 3 do not change it.
- R5: Status (read at address 4) bit 7 reads 0 from the start of a conversion until its done pulse, and reads 1 otherwise.
- R6: Status bit 6 follows the level of `ext_start_i` after a two-stage synchroniser.
- R7: When option bit 7 is set, a rising edge on `ext_start_i` starts one conversion. When option bit 7 is clear, the edge starts none.
- R8: When option bit 0 is set, each one-cycle pulse on `tmr_tc_i` starts one conversion. When option bit 0 is clear, the pulse starts none. The option register is written at address 4.
- R9: A trigger from any source that arrives while a conversion is in progress starts nothing.
- R10: When option bit 2 is set, each done pulse sets `irq_o`, shown as status bit 0. When option bit 2 is clear, completions leave `irq_o` low.
- R11: A status read clears a pending interrupt. If a completion with option bit 2 set falls in the same cycle as the read, `irq_o` stays set.
- R12: Writing the low four bits of address 5 drives `dio_pull_o`, where 1 pulls that line low. A read at address 5 returns `dio_pin_i`.
- R13: Address 3 holds a 7-bit sub-multiplexer select that drives `submux_o` and reads back as stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe (side effects only) |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | 8 | Write data byte |
| bus_rdata_o | output | 16 | Read data for the addressed register |
| ext_start_i | input | 1 | Asynchronous external start pin |
| tmr_tc_i | input | 1 | Timer terminal-count pulse |
| conv_start_o | output | 1 | One-cycle start strobe to the converter |
| conv_done_i | input | 1 | Converter done pulse |
| conv_data_i | input | 12 | Converter result, valid with done |
| chan_o | output | 4 | Selected channel |
| diff_o | output | 1 | Differential mode select |
| range_o | output | 3 | Range code |
| submux_o | output | 7 | Sub-multiplexer select outputs |
| dio_pull_o | output | 4 | Open-collector pull-down enables |
| dio_pin_i | input | 4 | Digital line levels |
| irq_o | output | 1 | End-of-conversion interrupt |

## Verification
The hardest case to reach is a status read that lands in the same cycle as a completion while an earlier interrupt is still pending. The bench gets there by letting one conversion finish with interrupts enabled and leaving it unacknowledged. It then starts a second conversion, watches the converter model's done pulse at the falling edge, and places the status read in exactly that cycle. Tag capture at start is shown by rewriting the sub-multiplexer select while the conversion is still busy.

// File: rtl/adc_regs_pkg.sv
package adc_regs_pkg;
   localparam int BYTE_W  = 8;
   localparam int ADDR_W  = 3;

   typedef enum logic [ADDR_W-1:0] {
      OFF_DATA   = 3'd0,
      OFF_SPARE  = 3'd1,
      OFF_CTRL   = 3'd2,
      OFF_SUBMUX = 3'd3,
      OFF_OPT    = 3'd4,
      OFF_DIO    = 3'd5
   } reg_off_e;

   // option byte bit positions
   localparam int OPT_CTR_BIT  = 0;
   localparam int OPT_EI_BIT   = 2;
   localparam int OPT_XSCE_BIT = 7;

   // status byte bit positions
   localparam int STAT_IDLE_BIT = 7;
   localparam int STAT_EXT_BIT  = 6;
   localparam int STAT_IRQ_BIT  = 0;

   typedef struct packed {
      logic xsce;
      logic ei;
      logic ctr;
   } opt_t;
endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_i,
   output logic level_o,
   output logic rise_o
);
   logic prev_q;

   generate
      if (STAGES == 0) begin : g_bypass
         assign level_o = pin_i;
      end else begin : g_sync
         logic [STAGES-1:0] sr_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sr_q <= '0;
            end else begin
               sr_q[0] <= pin_i;
               for (int i = 1; i < STAGES; i++) sr_q[i] <= sr_q[i-1];
            end
         end
         assign level_o = sr_q[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= level_o;
   end

   assign rise_o = level_o & ~prev_q;

   AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o) else $error("rise pulse longer than one cycle"); // R7
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
   import adc_regs_pkg::*;
#(
   parameter int DATA_W = 12,
   parameter int TAG_W  = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    sw_start_i,
   input  logic                    ext_rise_i,
   input  logic                    tmr_tc_i,
   input  opt_t                    opt_i,
   input  logic [TAG_W-1:0]        tag_i,
   input  logic                    conv_done_i,
   input  logic [DATA_W-1:0]       conv_data_i,
   input  logic                    irq_ack_i,
   output logic                    conv_start_o,
   output logic                    busy_o,
   output logic [DATA_W+TAG_W-1:0] result_o,
   output logic                    irq_o
);
   localparam int RES_W = DATA_W + TAG_W;

   logic             busy_q, start_q, irq_q, trig, finish;
   logic [TAG_W-1:0] tag_hold_q;
   logic [RES_W-1:0] result_q;

   assign trig   = ~busy_q & (sw_start_i | (ext_rise_i & opt_i.xsce) | (tmr_tc_i & opt_i.ctr));
   assign finish = busy_q & conv_done_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         start_q    <= 1'b0;
         tag_hold_q <= '0;
         result_q   <= '0;
      end else begin
         start_q <= trig;
         if (trig) begin
            busy_q     <= 1'b1;
            tag_hold_q <= tag_i;
         end else if (finish) begin
            busy_q   <= 1'b0;
            result_q <= {tag_hold_q, conv_data_i};
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                 irq_q <= 1'b0;
      else if (finish && opt_i.ei) irq_q <= 1'b1;
      else if (irq_ack_i)         irq_q <= 1'b0;
   end

   assign conv_start_o = start_q;
   assign busy_o       = busy_q;
   assign result_o     = result_q;
   assign irq_o        = irq_q;

   AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      start_q |=> !start_q) else $error("start strobe not a single pulse"); // R2
   AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !conv_done_i) |=> !start_q) else $error("start while busy"); // R9
   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !conv_done_i) |=> busy_q) else $error("busy dropped early"); // R5
   AST_IRQ_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (finish && opt_i.ei) |=> irq_q) else $error("completion did not raise irq"); // R10
   AST_IRQ_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && irq_ack_i && !finish) |=> !irq_q) else $error("ack did not clear irq"); // R11
endmodule

// File: rtl/adc_reg_file.sv
module adc_reg_file
   import adc_regs_pkg::*;
#(
   parameter int CHAN_W   = 4,
   parameter int RANGE_W  = 3,
   parameter int SUBMUX_W = 7,
   parameter int DIO_W    = 4,
   parameter int RD_W     = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_i,
   input  logic                rd_i,
   input  logic [ADDR_W-1:0]   addr_i,
   input  logic [BYTE_W-1:0]   wdata_i,
   output logic [RD_W-1:0]     rdata_o,
   input  logic [RD_W-1:0]     result_i,
   input  logic                busy_i,
   input  logic                ext_level_i,
   input  logic                irq_i,
   input  logic [DIO_W-1:0]    dio_pin_i,
   output logic [CHAN_W-1:0]   chan_o,
   output logic                diff_o,
   output logic [RANGE_W-1:0]  range_o,
   output logic [SUBMUX_W-1:0] submux_o,
   output logic [DIO_W-1:0]    dio_pull_o,
   output opt_t                opt_o,
   output logic                sw_start_o,
   output logic                stat_rd_o
);
   localparam int CTRL_W   = CHAN_W + 1 + RANGE_W;
   localparam int DIFF_BIT = RANGE_W;

   logic [CTRL_W-1:0]   ctrl_q, ctrl_d;
   logic [SUBMUX_W-1:0] submux_q;
   logic [DIO_W-1:0]    dio_q;
   opt_t                opt_q;
   logic [BYTE_W-1:0]   status;
   logic                wr_ctrl, wr_sub, wr_opt, wr_dio;

   generate
      if (CTRL_W != BYTE_W) begin : g_bad_ctrl
         $error("control fields must fill one byte");
      end
   endgenerate

   assign wr_ctrl = wr_i && (addr_i == OFF_CTRL);
   assign wr_sub  = wr_i && (addr_i == OFF_SUBMUX);
   assign wr_opt  = wr_i && (addr_i == OFF_OPT);
   assign wr_dio  = wr_i && (addr_i == OFF_DIO);

   // differential mode: top channel bit forced low
   always_comb begin
      ctrl_d = wdata_i[CTRL_W-1:0];
      if (wdata_i[DIFF_BIT]) ctrl_d[CTRL_W-1] = 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         submux_q <= '0;
         dio_q    <= '0;
         opt_q    <= '0;
      end else begin
         if (wr_ctrl) ctrl_q   <= ctrl_d;
         if (wr_sub)  submux_q <= wdata_i[SUBMUX_W-1:0];
         if (wr_dio)  dio_q    <= wdata_i[DIO_W-1:0];
         if (wr_opt)  opt_q    <= '{xsce: wdata_i[OPT_XSCE_BIT],
                                    ei:   wdata_i[OPT_EI_BIT],
                                    ctr:  wdata_i[OPT_CTR_BIT]};
      end
   end

   always_comb begin
      status                = '0;
      status[STAT_IDLE_BIT] = ~busy_i;
      status[STAT_EXT_BIT]  = ext_level_i;
      status[STAT_IRQ_BIT]  = irq_i;
   end

   always_comb begin
      case (addr_i)
         OFF_DATA:   rdata_o = result_i;
         OFF_CTRL:   rdata_o = {{(RD_W-CTRL_W){1'b0}}, ctrl_q};
         OFF_SUBMUX: rdata_o = {{(RD_W-SUBMUX_W){1'b0}}, submux_q};
         OFF_OPT:    rdata_o = {{(RD_W-BYTE_W){1'b0}}, status};
         OFF_DIO:    rdata_o = {{(RD_W-DIO_W){1'b0}}, dio_pin_i};
         default:    rdata_o = '0;
      endcase
   end

   assign chan_o     = ctrl_q[CTRL_W-1 -: CHAN_W];
   assign diff_o     = ctrl_q[DIFF_BIT];
   assign range_o    = ctrl_q[RANGE_W-1:0];
   assign submux_o   = submux_q;
   assign dio_pull_o = dio_q;
   assign opt_o      = opt_q;
   assign sw_start_o = wr_i && (addr_i == OFF_DATA);
   assign stat_rd_o  = rd_i && (addr_i == OFF_OPT);

   AST_DIFF_CHAN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      diff_o |-> !chan_o[CHAN_W-1]) else $error("differential with high channel"); // R3
   AST_DIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_dio |=> $stable(dio_pull_o)) else $error("dio changed without write"); // R12
   AST_SUBMUX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_sub |=> $stable(submux_o)) else $error("submux changed without write"); // R13
endmodule

// File: rtl/adc_regs_ctrl.sv
module adc_regs_ctrl
   import adc_regs_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int TAG_W       = 4,
   parameter int CHAN_W      = 4,
   parameter int RANGE_W     = 3,
   parameter int SUBMUX_W    = 7,
   parameter int DIO_W       = 4,
   parameter int SYNC_STAGES = 2,
   localparam int RD_W       = DATA_W + TAG_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_wr_i,
   input  logic                bus_rd_i,
   input  logic [ADDR_W-1:0]   bus_addr_i,
   input  logic [BYTE_W-1:0]   bus_wdata_i,
   output logic [RD_W-1:0]     bus_rdata_o,
   input  logic                ext_start_i,
   input  logic                tmr_tc_i,
   output logic                conv_start_o,
   input  logic                conv_done_i,
   input  logic [DATA_W-1:0]   conv_data_i,
   output logic [CHAN_W-1:0]   chan_o,
   output logic                diff_o,
   output logic [RANGE_W-1:0]  range_o,
   output logic [SUBMUX_W-1:0] submux_o,
   output logic [DIO_W-1:0]    dio_pull_o,
   input  logic [DIO_W-1:0]    dio_pin_i,
   output logic                irq_o
);
   generate
      if (TAG_W > SUBMUX_W) begin : g_bad_tag
         $error("tag wider than sub-multiplexer field");
      end
      if (SUBMUX_W > BYTE_W || DIO_W > BYTE_W) begin : g_bad_byte
         $error("register field wider than a byte");
      end
   endgenerate

   logic ext_level, ext_rise, sw_start, stat_rd, busy, irq;
   logic [RD_W-1:0] result;
   opt_t opt;

   adc_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
      .clk(clk), .rst_n(rst_n), .pin_i(ext_start_i),
      .level_o(ext_level), .rise_o(ext_rise)
   );

   adc_reg_file #(
      .CHAN_W(CHAN_W), .RANGE_W(RANGE_W), .SUBMUX_W(SUBMUX_W),
      .DIO_W(DIO_W), .RD_W(RD_W)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_i(bus_wr_i), .rd_i(bus_rd_i),
      .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o),
      .result_i(result), .busy_i(busy), .ext_level_i(ext_level), .irq_i(irq),
      .dio_pin_i(dio_pin_i), .chan_o(chan_o), .diff_o(diff_o), .range_o(range_o),
      .submux_o(submux_o), .dio_pull_o(dio_pull_o), .opt_o(opt),
      .sw_start_o(sw_start), .stat_rd_o(stat_rd)
   );

   adc_conv_seq #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .sw_start_i(sw_start), .ext_rise_i(ext_rise),
      .tmr_tc_i(tmr_tc_i), .opt_i(opt), .tag_i(submux_o[TAG_W-1:0]),
      .conv_done_i(conv_done_i), .conv_data_i(conv_data_i), .irq_ack_i(stat_rd),
      .conv_start_o(conv_start_o), .busy_o(busy), .result_o(result), .irq_o(irq)
   );

   assign irq_o = irq;

   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start_o |-> !$past(conv_start_o)) else $error("back-to-back starts"); // R9
endmodule

// File: tb/adc_regs_ctrl_tb_top.sv
module adc_regs_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        ext_start = 1'b0, tmr_tc = 1'b0;
   logic        conv_start, conv_done;
   logic [11:0] conv_data = '0;
   logic [3:0]  chan;
   logic        diff;
   logic [2:0]  range_sel;
   logic [6:0]  submux;
   logic [3:0]  dio_pull, dio_pin;
   logic [3:0]  ext_drv = 4'hF;
   logic        irq;
   logic [3:0]  lat_q = '0;
   int          n_starts = 0;
   int          checks = 0, errors = 0;

   always #10 clk = ~clk;

   adc_regs_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
      .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
      .ext_start_i(ext_start), .tmr_tc_i(tmr_tc), .conv_start_o(conv_start),
      .conv_done_i(conv_done), .conv_data_i(conv_data), .chan_o(chan),
      .diff_o(diff), .range_o(range_sel), .submux_o(submux),
      .dio_pull_o(dio_pull), .dio_pin_i(dio_pin), .irq_o(irq)
   );

   // converter model: done four cycles after the start strobe
   always @(posedge clk) begin
      if (!rst_n)             lat_q <= '0;
      else if (conv_start)    lat_q <= 4'd4;
      else if (lat_q != 4'd0) lat_q <= lat_q - 4'd1;
      if (rst_n && conv_start) n_starts <= n_starts + 1;
   end
   assign conv_done = (lat_q == 4'd1);
   assign dio_pin   = ext_drv & ~dio_pull;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] v);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 v = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (1000000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] v;
      int base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(3'd4, v);  chk(v == 16'h0080, "R1 status", v, 16'h0080);
      rd(3'd2, v);  chk(v == 16'h0000, "R1 control", v, 0);
      chk({irq, dio_pull, submux} == '0, "R1 outputs", {irq, dio_pull, submux}, 0);
      chk(n_starts == 0, "R1 no start", n_starts, 0);

      // R3 every control byte
      for (int c = 0; c < 256; c++) begin
         logic [7:0] e;
         e = c[3] ? (c[7:0] & 8'h7F) : c[7:0];
         wr(3'd2, c[7:0]);
         rd(3'd2, v);
         chk(v == {8'h00, e}, "R3 readback", v, e);
         chk({chan, diff, range_sel} == e, "R3 fields", {chan, diff, range_sel}, e);
      end

      // R13 every sub-multiplexer value
      for (int s = 0; s < 128; s++) begin
         wr(3'd3, s[7:0]);
         rd(3'd3, v);
         chk(v == s[15:0] && submux == s[6:0], "R13 submux", {v, 1'b0, submux}, {s[15:0], 1'b0, s[6:0]});
      end

      // R12 digital lines
      for (int o = 0; o < 16; o++) begin
         for (int k = 0; k < 3; k++) begin
            logic [3:0] ed;
            ed = (k == 0) ? 4'hF : (k == 1) ? 4'hA : 4'h5;
            ext_drv = ed;
            wr(3'd5, {4'hC, o[3:0]});
            rd(3'd5, v);
            chk(v == {12'h0, ed & ~o[3:0]} && dio_pull == o[3:0], "R12 dio",
                {v, dio_pull}, {12'h0, ed & ~o[3:0], o[3:0]});
         end
      end

      // R2 R4 R5 software starts with tag captured at start
      for (int k = 0; k < 8; k++) begin
         logic [3:0]  tg;
         logic [11:0] dv;
         tg = 4'(k * 5 + 3);
         dv = 12'(k * 517 + 291);
         conv_data = dv;
         wr(3'd3, {4'h0, tg});
         base = n_starts;
         wr(3'd0, 8'(k));
         rd(3'd4, v);
         chk(v[7] == 1'b0, "R5 busy during conversion", v, 0);
         wr(3'd3, {4'h0, ~tg});
         idle(6);
         chk(n_starts == base + 1, "R2 one start", n_starts, base + 1);
         rd(3'd4, v);
         chk(v[7] == 1'b1, "R5 idle after done", v, 16'h0080);
         rd(3'd0, v);
         chk(v == {tg, dv}, "R4 result and tag", v, {tg, dv});
      end

      // R9 second write while busy
      base = n_starts;
      wr(3'd0, 8'h00);
      wr(3'd0, 8'h00);
      wr(3'd1, 8'h00);
      idle(6);
      chk(n_starts == base + 1, "R9 retrigger ignored", n_starts, base + 1);

      // R6 R7 external start
      wr(3'd4, 8'h80);
      base = n_starts;
      @(negedge clk) ext_start = 1'b1;
      idle(8);
      chk(n_starts == base + 1, "R7 edge starts", n_starts, base + 1);
      rd(3'd4, v);
      chk(v[6] == 1'b1, "R6 ext high", v, 16'h00C0);
      @(negedge clk) ext_start = 1'b0;
      idle(4);
      rd(3'd4, v);
      chk(v[6] == 1'b0, "R6 ext low", v, 16'h0080);
      wr(3'd4, 8'h00);
      base = n_starts;
      @(negedge clk) ext_start = 1'b1;
      idle(8);
      chk(n_starts == base, "R7 edge without enable", n_starts, base);
      @(negedge clk) ext_start = 1'b0;

      // R8 timer pulses
      wr(3'd4, 8'h01);
      base = n_starts;
      for (int p = 0; p < 3; p++) begin
         @(negedge clk) tmr_tc = 1'b1;
         @(negedge clk) tmr_tc = 1'b0;
         idle(8);
      end
      chk(n_starts == base + 3, "R8 each pulse starts", n_starts, base + 3);
      wr(3'd4, 8'h00);
      base = n_starts;
      @(negedge clk) tmr_tc = 1'b1;
      @(negedge clk) tmr_tc = 1'b0;
      idle(8);
      chk(n_starts == base, "R8 pulse without enable", n_starts, base);

      // R10 interrupt enable
      wr(3'd4, 8'h04);
      wr(3'd0, 8'h00);
      idle(7);
      chk(irq == 1'b1, "R10 irq set", irq, 1);
      rd(3'd4, v);
      chk(v[0] == 1'b1, "R10 status irq bit", v, 16'h0081);
      chk(irq == 1'b0, "R11 read clears", irq, 0);
      wr(3'd4, 8'h00);
      wr(3'd0, 8'h00);
      idle(7);
      chk(irq == 1'b0, "R10 no irq when disabled", irq, 0);

      // R11 read coincides with completion
      wr(3'd4, 8'h04);
      wr(3'd0, 8'h00);
      idle(7);
      wr(3'd0, 8'h00);
      while (!conv_done) @(negedge clk);
      bus_addr = 3'd4; bus_rd = 1'b1;
      @(negedge clk) bus_rd = 1'b0;
      chk(irq == 1'b1, "R11 completion wins", irq, 1);
      rd(3'd4, v);
      chk(irq == 1'b0, "R11 later read clears", irq, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule